// File: doc/BRIEF.md
# Multi-Mode PWM Time Base

This block is the counting engine behind a PWM generator. It has a 15-bit counter that runs against a programmable period. A 2-bit mode field sets what happens when the counter reaches the period. In free running mode the counter wraps to zero. In single shot mode it wraps once and then stops itself. In the two up/down modes it turns around and counts back down to zero, which gives the triangular sweep used for center-aligned PWM. A prescaler, fed by an external count-enable tick, sets how fast the counter advances. An interrupt postscaler thins out the interrupt events in the modes that allow it.

A controller loads the period value, picks the mode and the ratios, and sets the enable bit. It then reads the counter value. Bit 15 of that value shows the count direction. The block raises a one-cycle interrupt at the count events that belong to the mode. In single shot mode the block clears its own enable bit when the run ends. A period written while the counter runs is held back until the counter is at zero, so a running ramp is never cut short.

Top module: `ptb_timebase`

## Requirements
- R1: While reset is asserted and just after its release, `cnt_o` reads 0, `irq_o` is 0 and `en_o` is 0.
- R2: The counter advances only on a prescaled step. A step happens on the clock where the block is enabled, `tick_i` is high, and it is the 1st, 4th, 16th or 64th such tick for `pre_i` = 0, 1, 2, 3 respectively. While `tick_i` is low the counter holds its value.
- R3: In mode 0 (free running) the counter steps 0,1,...,P and returns to 0 on the step after it reaches P. Bit 15 of `cnt_o` stays 0.
- R4: In mode 1 (single shot) the counter steps 0 to P. On the next step it returns to 0, `en_o` falls and `irq_o` pulses once. The postscaler select has no effect in this mode.
- R5: In modes 2 and 3 the counter steps up to P and then down to 0, then up again. `cnt_o[15]` is 1 exactly while the counter holds a value it reached on the way down, other than 0.
- R6: In mode 2, reaching 0 from above is an interrupt event that goes through the postscaler.
- R7: In mode 3, both the step leaving P and the step reaching 0 raise `irq_o` directly, whatever the postscaler select is.
- R8: With postscaler select N (4 bits), modes 0 and 2 pulse `irq_o` on every (N+1)-th event. The count of events seen so far is reset whenever the block is disabled.
- R9: Clearing the enable bit freezes the counter value and direction. Setting it again resumes from that exact state.
- R10: With a period of 0 the counter does not move and no interrupt occurs. A period written while the block is enabled in that state is discarded. A period written while the block is disabled takes effect at once.
- R11: A period written while the block is enabled with a non-zero period is loaded only once the counter sits at 0. Until then the counter still runs to the old period.
- R12: With a period of 1 the counter alternates 0 and 1 without ever showing the down flag. Every second step is an interrupt event in every repeating mode.
- All writes are sampled on the rising clock edge. `irq_o` and the counter change on the same edge as the step that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count-enable tick feeding the prescaler |
| en_we_i | input | 1 | Write strobe for the enable bit |
| en_wd_i | input | 1 | Enable value written on `en_we_i` |
| per_we_i | input | 1 | Write strobe for the period value |
| per_wd_i | input | 15 | Period value written on `per_we_i` |
| mode_i | input | 2 | 0 free running, 1 single shot, 2 up/down, 3 up/down with double events |
| ops_i | input | 4 | Postscaler select N, ratio 1:(N+1) |
| pre_i | input | 2 | Prescaler select, 1/4/16/64 ticks per step |
| cnt_o | output | 16 | Counter value in bits 14:0, down-count flag in bit 15 |
| irq_o | output | 1 | One-cycle interrupt pulse |
| en_o | output | 1 | Current enable bit, cleared by hardware at the end of a single shot |

## Verification
With the enable written on edge E0 and `tick_i` held high, step k lands on edge E0 + k·R, where R is the prescale ratio. The counter value, the down flag, the interrupt pulse and the fall of `en_o` all become visible on that same edge. No extra cycle is added by a pipeline stage. Period and enable writes take effect on the edge that samples them. A deferred period is loaded on the first edge that sees the counter at zero. The bench drives and samples at the falling edge only. It recomputes each expected value from the edge count, using modulo arithmetic over 2P or P+1 steps and over N+1 events. It then compares after every edge of a run, so no latency is assumed more loosely than one cycle.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_ONCE  = 2'd1,
    MODE_UPDN  = 2'd2,
    MODE_UPDN2 = 2'd3
  } ptb_mode_e;
endpackage

// File: rtl/ptb_prescale.sv
module ptb_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int DIV_W = 2 * ((1 << SEL_W) - 1);

  logic [DIV_W-1:0] div_q, div_d, last;
  logic [DIV_W:0]   ratio;
  logic             wrap;

  always_comb begin
    ratio  = (DIV_W+1)'(1) << {sel_i, 1'b0};
    last   = DIV_W'(ratio - 1'b1);
    wrap   = (div_q >= last);
    step_o = run_i && tick_i && wrap;
    div_d  = div_q;
    if (!run_i) begin
      div_d = '0;
    end else if (tick_i) begin
      div_d = wrap ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ptb_postscale.sv
module ptb_postscale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ev_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fire_o
);
  logic [SEL_W-1:0] seen_q, seen_d;

  always_comb begin
    fire_o = ev_i && (seen_q >= sel_i);
    seen_d = seen_q;
    if (!run_i) begin
      seen_d = '0;
    end else if (ev_i) begin
      seen_d = fire_o ? '0 : seen_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/ptb_core.sv
module ptb_core
  import ptb_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [1:0]       mode_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_wd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             post_ev_o,
  output logic             direct_ev_o,
  output logic             once_done_o
);
  ptb_mode_e        mode;
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, shd_q, shd_d, dec;
  logic             dir_q, dir_d, pend_q, pend_d, at_top, live;

  assign mode  = ptb_mode_e'(mode_i);
  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  // period: immediate while stopped, deferred to the zero point while running
  always_comb begin
    per_d  = per_q;
    shd_d  = shd_q;
    pend_d = pend_q;
    if (per_we_i) begin
      if (!run_i) begin
        per_d  = per_wd_i;
        pend_d = 1'b0;
      end else if (per_q != '0) begin
        shd_d  = per_wd_i;
        pend_d = 1'b1;
      end
    end else if (pend_q && run_i && (cnt_q == '0) && (per_q != '0)) begin
      per_d  = shd_q;
      pend_d = 1'b0;
    end
  end

  // counter next state
  always_comb begin
    dec         = cnt_q - 1'b1;
    at_top      = (cnt_q >= per_q);
    live        = step_i && (per_q != '0);
    cnt_d       = cnt_q;
    dir_d       = dir_q;
    post_ev_o   = 1'b0;
    direct_ev_o = 1'b0;
    once_done_o = 1'b0;
    if (live) begin
      if (!dir_q && !at_top) begin
        cnt_d = cnt_q + 1'b1;
      end else if (!dir_q && (mode == MODE_FREE || mode == MODE_ONCE)) begin
        cnt_d = '0;
        if (mode == MODE_FREE) begin
          post_ev_o = 1'b1;
        end else begin
          direct_ev_o = 1'b1;
          once_done_o = 1'b1;
        end
      end else begin
        cnt_d = dec;
        if (mode == MODE_UPDN2 && !dir_q) direct_ev_o = 1'b1;
        if (dec == '0) begin
          dir_d = 1'b0;
          if (mode == MODE_UPDN)       post_ev_o   = 1'b1;
          else if (mode == MODE_UPDN2) direct_ev_o = 1'b1;
        end else begin
          dir_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      per_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      per_q  <= per_d;
      shd_q  <= shd_d;
      pend_q <= pend_d;
    end
  end

  a_r3_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && per_q != '0 && mode == MODE_FREE && !dir_q && cnt_q == per_q) |=> (cnt_q == '0));

  a_r5_down_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q |-> (cnt_q != '0));

  a_r10_zero_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0) |=> ($stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase #(
  parameter int CNT_W = 15,
  parameter int OPS_W = 4,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_we_i,
  input  logic             en_wd_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_wd_i,
  input  logic [1:0]       mode_i,
  input  logic [OPS_W-1:0] ops_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W:0]   cnt_o,
  output logic             irq_o,
  output logic             en_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             en_q, en_d, irq_q, irq_d;
  logic             step, post_ev, direct_ev, once_done, fire, dir;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ptb_prescale #(.SEL_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run_i(en_q), .tick_i(tick_i),
    .sel_i(pre_i), .step_o(step)
  );

  ptb_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .run_i(en_q), .step_i(step),
    .mode_i(mode_i), .per_we_i(per_we_i), .per_wd_i(per_wd_i),
    .cnt_o(cnt), .dir_o(dir), .post_ev_o(post_ev),
    .direct_ev_o(direct_ev), .once_done_o(once_done)
  );

  ptb_postscale #(.SEL_W(OPS_W)) u_post (
    .clk(clk), .rst_n(rst_int_n), .run_i(en_q), .ev_i(post_ev),
    .sel_i(ops_i), .fire_o(fire)
  );

  always_comb begin
    en_d  = en_q;
    if (en_we_i)        en_d = en_wd_i;
    else if (once_done) en_d = 1'b0;
    irq_d = direct_ev | fire;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = {dir, cnt};
  assign irq_o = irq_q;
  assign en_o  = en_q;

  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    !step |=> $stable(cnt_o));

  a_r4_single_shot_stops: assert property (@(posedge clk) disable iff (!rst_int_n)
    (once_done && !en_we_i) |=> !en_q);
endmodule

// File: tb/ptb_timebase_tb.sv
module ptb_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n, tick_i, en_we_i, en_wd_i, per_we_i;
  logic [14:0] per_wd_i;
  logic [1:0]  mode_i, pre_i;
  logic [3:0]  ops_i;
  logic [15:0] cnt_o;
  logic        irq_o, en_o;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptb_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_we_i(en_we_i), .en_wd_i(en_wd_i),
    .per_we_i(per_we_i), .per_wd_i(per_wd_i), .mode_i(mode_i), .ops_i(ops_i),
    .pre_i(pre_i), .cnt_o(cnt_o), .irq_o(irq_o), .en_o(en_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 1'b1; en_we_i = 1'b0; en_wd_i = 1'b0;
    per_we_i = 1'b0; per_wd_i = '0; mode_i = '0; pre_i = '0; ops_i = '0;
    step_n(2);
    rst_n = 1'b1;
    step_n(3);
  endtask

  task automatic pulse_en(input bit v);
    en_we_i = 1'b1; en_wd_i = v;
    step_n(1);
    en_we_i = 1'b0;
  endtask

  task automatic write_per(input int v);
    per_we_i = 1'b1; per_wd_i = 15'(v);
    step_n(1);
    per_we_i = 1'b0;
  endtask

  task automatic sweep(input int md, input int p, input int pre, input int n);
    int r, w;
    do_reset();
    mode_i = 2'(md); pre_i = 2'(pre); ops_i = 4'(n);
    write_per(p);
    pulse_en(1'b1);
    r = 1 << (2 * pre);
    w = 2 * (n + 1) * 2 * p * r + 2 * r;
    for (int c = 1; c <= w; c++) begin
      int s, t, ecnt, edir, eirq, een;
      bit stp;
      string rc, ri;
      step_n(1);
      s = c / r; stp = (c % r == 0);
      edir = 0; een = 1; eirq = 0;
      if (md == 0) begin
        ecnt = s % (p + 1);
        eirq = int'(stp && s > 0 && s % ((n + 1) * (p + 1)) == 0);
        rc = "R3"; ri = "R8";
      end else if (md == 1) begin
        ecnt = (s <= p) ? s : 0;
        een  = (s <= p) ? 1 : 0;
        eirq = int'(c == (p + 1) * r);
        rc = "R4"; ri = "R4";
      end else begin
        t = s % (2 * p);
        ecnt = (t <= p) ? t : 2 * p - t;
        edir = (t > p) ? 1 : 0;
        if (md == 2) begin
          eirq = int'(stp && s > 0 && s % (2 * p * (n + 1)) == 0);
          ri = "R6";
        end else begin
          eirq = int'(stp && s > 0 && (t == 0 || t == (p + 1) % (2 * p)));
          ri = "R7";
        end
        rc = "R5";
      end
      if (p == 1) rc = "R12";
      if (pre != 0 && (c % r) != 0 && (c % r) != 1) rc = "R2";
      chk(rc, "cnt", int'(cnt_o), edir * 32768 + ecnt);
      chk(ri, "irq", int'(irq_o), eirq);
      chk("R4", "en", int'(en_o), een);
    end
  endtask

  initial begin
    int plist[3] = '{1, 2, 5};
    rst_n = 1'b0; tick_i = 1'b1; en_we_i = 1'b0; en_wd_i = 1'b0;
    per_we_i = 1'b0; per_wd_i = '0; mode_i = '0; pre_i = '0; ops_i = '0;

    // R1 reset state, during and after reset
    step_n(1);
    chk("R1", "cnt in reset", int'(cnt_o), 0);
    chk("R1", "irq in reset", int'(irq_o), 0);
    do_reset();
    chk("R1", "cnt", int'(cnt_o), 0);
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "en", int'(en_o), 0);

    // R2 tick gating with prescale 4
    do_reset();
    tick_i = 1'b0; pre_i = 2'd1;
    write_per(7);
    pulse_en(1'b1);
    step_n(10); chk("R2", "cnt no tick", int'(cnt_o), 0);
    tick_i = 1'b1; step_n(8); chk("R2", "cnt 8 ticks", int'(cnt_o), 2);
    tick_i = 1'b0; step_n(5); chk("R2", "cnt hold", int'(cnt_o), 2);
    tick_i = 1'b1; step_n(4); chk("R2", "cnt 4 more", int'(cnt_o), 3);

    // R9 freeze on disable in up/down, resume from frozen state
    do_reset();
    mode_i = 2'd2;
    write_per(4);
    pulse_en(1'b1);
    step_n(6); chk("R9", "cnt descending", int'(cnt_o), 32770);
    pulse_en(1'b0); chk("R9", "cnt last step", int'(cnt_o), 32769);
    step_n(5);
    chk("R9", "cnt frozen", int'(cnt_o), 32769);
    chk("R9", "en off", int'(en_o), 0);
    chk("R9", "irq off", int'(irq_o), 0);
    pulse_en(1'b1); chk("R9", "cnt on re-enable", int'(cnt_o), 32769);
    step_n(1);
    chk("R9", "cnt resumed", int'(cnt_o), 0);
    chk("R9", "irq at zero", int'(irq_o), 1);

    // R8 postscaler count cleared on disable
    do_reset();
    ops_i = 4'd2;
    write_per(1);
    pulse_en(1'b1);
    step_n(4); chk("R8", "irq two events", int'(irq_o), 0);
    pulse_en(1'b0);
    pulse_en(1'b1);
    step_n(1);
    chk("R8", "cnt restart", int'(cnt_o), 0);
    chk("R8", "irq first event after restart", int'(irq_o), 0);
    step_n(2); chk("R8", "irq second event", int'(irq_o), 0);
    step_n(2); chk("R8", "irq third event", int'(irq_o), 1);

    // R10 zero period
    do_reset();
    pulse_en(1'b1);
    for (int i = 0; i < 8; i++) begin
      step_n(1);
      chk("R10", "cnt zero period", int'(cnt_o), 0);
      chk("R10", "irq zero period", int'(irq_o), 0);
    end
    write_per(3);
    for (int i = 0; i < 8; i++) begin
      step_n(1);
      chk("R10", "cnt write ignored", int'(cnt_o), 0);
      chk("R10", "irq write ignored", int'(irq_o), 0);
    end
    pulse_en(1'b0);
    write_per(3);
    pulse_en(1'b1);
    step_n(2); chk("R10", "cnt after disabled write", int'(cnt_o), 2);
    step_n(2);
    chk("R10", "cnt wrap", int'(cnt_o), 0);
    chk("R10", "irq wrap", int'(irq_o), 1);

    // R11 deferred period load
    do_reset();
    write_per(5);
    pulse_en(1'b1);
    step_n(3); chk("R11", "cnt before write", int'(cnt_o), 3);
    write_per(2); chk("R11", "cnt at write", int'(cnt_o), 4);
    step_n(1); chk("R11", "old period kept", int'(cnt_o), 5);
    step_n(1);
    chk("R11", "cnt old wrap", int'(cnt_o), 0);
    chk("R11", "irq old wrap", int'(irq_o), 1);
    step_n(2); chk("R11", "cnt new top", int'(cnt_o), 2);
    step_n(1);
    chk("R11", "cnt new wrap", int'(cnt_o), 0);
    chk("R11", "irq new wrap", int'(irq_o), 1);

    // sweep over modes, periods, prescale and postscale
    for (int md = 0; md < 4; md++)
      for (int pi = 0; pi < 3; pi++)
        for (int pre = 0; pre < 4; pre++)
          for (int n = 0; n <= 2; n += 2)
            sweep(md, plist[pi], pre, n);

    // R4 single shot can be restarted
    do_reset();
    mode_i = 2'd1;
    write_per(2);
    pulse_en(1'b1);
    step_n(3); chk("R4", "en after shot", int'(en_o), 0);
    pulse_en(1'b1);
    step_n(2); chk("R4", "cnt second shot", int'(cnt_o), 2);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 195000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule